// File: doc/BRIEF.md
# JTAG-to-SPI Flash Bridge TAP

This block is a small soft test access port that lets a JTAG host program or read a serial flash hanging off the chip. It has a full TAP controller, a 6-bit instruction register, a one-bit bypass register and a 32-bit identification register. When the instruction register holds the flash-access opcode (0x02), the serial flash itself becomes the data register. Scan-clock and scan-input go straight to the flash clock and data-in pins. Chip select is asserted only while the controller sits in Shift-DR.

The flash's serial output is captured on the rising scan-clock edge and presented on TDO at the next falling edge. So every flash shift returns one leading bit that the host drops before the real read data. The host builds flash commands, addresses and data itself and shifts them most-significant bit first. The bridge knows nothing about flash commands. To end a flash transaction the host leaves Shift-DR; a detour through Pause-DR opens a new one.

All interfaces are plain JTAG and SPI pins with no flow control: the scan clock sets the pace, and nothing can stall it.

Top module: `scan_flash_bridge`

## Requirements
- R1: Five consecutive rising scan-clock edges with TMS high put the controller into Test-Logic-Reset from any state, which reselects the identification instruction.
- R2: After reset the instruction register holds the identification opcode 0x09. A data scan then captures the 32-bit ID (default 0x0A571E4D) in Capture-DR and shifts it out least-significant bit first.
- R3: In Capture-IR the instruction shifter loads 000001, which is shifted out least-significant bit first. A newly shifted opcode takes effect only in Update-IR, or on reset.
- R4: Opcode 0x3F (all ones), and any opcode other than 0x02 and 0x09, selects a one-bit bypass register. It captures 0, then delays TDI by exactly one scan clock.
- R5: spi_cs_n is low only while the instruction register holds 0x02 and the controller is in Shift-DR. It is high in every other state and with every other opcode.
- R6: spi_sclk always equals tck, and spi_mosi always equals tdi, with no register on the way.
- R7: spi_miso is sampled on each rising scan-clock edge and appears on TDO at the following falling edge. The first TDO bit of a flash shift is therefore the MISO level from before selection.
- R8: Bits reach the flash in the order they were shifted, none added and none lost. A host sending most-significant bit first thus delivers whole bytes in that order.
- R9: spi_cs_n rises on the edge that leaves Shift-DR. Going back to Shift-DR through Pause-DR and Exit2-DR starts a new flash transaction whose data begins again from its first bit.
- R10: TDO changes only on the falling scan-clock edge and is driven low outside Shift-IR and Shift-DR.
- R11: trst_n low forces, without waiting for a clock, Test-Logic-Reset, the identification instruction, spi_cs_n high and TDO low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Scan clock, also forwarded as the flash clock |
| trst_n | input | 1 | Asynchronous active-low TAP reset |
| tms | input | 1 | Test mode select, sampled on rising tck |
| tdi | input | 1 | Scan data in, forwarded as flash data in |
| tdo | output | 1 | Scan data out, updated on falling tck |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Flash serial clock |
| spi_mosi | output | 1 | Flash serial data in |
| spi_miso | input | 1 | Flash serial data out |

## Verification
On every clock the assertions check the following:
- the TMS-high escape to reset;
- that the instruction register moves only in Update-IR or reset;
- the bypass one-clock delay;
- the MISO-to-TDO retiming;
- that chip select can fall only on entry to Shift-DR and always rises when TMS leaves it;
- that TDO rests low outside the shift states.

Only the bench's scenarios show end-to-end behaviour, using a flash model on the SPI pins. These cover the identification value and the IR capture pattern, the bit order of whole bytes arriving at the flash, the discarded leading read bit, the restart of a transaction after a pause, and recovery from an asynchronous reset in the middle of a shift.

// File: rtl/sfb_pkg.sv
`timescale 1ns/1ps
package sfb_pkg;

  typedef enum logic [3:0] {
    TS_RESET    = 4'h0,
    TS_IDLE     = 4'h1,
    TS_SEL_DR   = 4'h2,
    TS_CAP_DR   = 4'h3,
    TS_SHIFT_DR = 4'h4,
    TS_EXIT1_DR = 4'h5,
    TS_PAUSE_DR = 4'h6,
    TS_EXIT2_DR = 4'h7,
    TS_UPD_DR   = 4'h8,
    TS_SEL_IR   = 4'h9,
    TS_CAP_IR   = 4'hA,
    TS_SHIFT_IR = 4'hB,
    TS_EXIT1_IR = 4'hC,
    TS_PAUSE_IR = 4'hD,
    TS_EXIT2_IR = 4'hE,
    TS_UPD_IR   = 4'hF
  } tap_state_e;

  // number of TMS-high clocks that always reach Test-Logic-Reset
  localparam int unsigned RESET_ONES = 5;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    tap_state_e n;
    case (s)
      TS_RESET:    n = m ? TS_RESET    : TS_IDLE;
      TS_IDLE:     n = m ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_DR:   n = m ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   n = m ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_SHIFT_DR: n = m ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_EXIT1_DR: n = m ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: n = m ? TS_EXIT2_DR : TS_PAUSE_DR;
      TS_EXIT2_DR: n = m ? TS_UPD_DR   : TS_SHIFT_DR;
      TS_UPD_DR:   n = m ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_IR:   n = m ? TS_RESET    : TS_CAP_IR;
      TS_CAP_IR:   n = m ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_SHIFT_IR: n = m ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_EXIT1_IR: n = m ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: n = m ? TS_EXIT2_IR : TS_PAUSE_IR;
      TS_EXIT2_IR: n = m ? TS_UPD_IR   : TS_SHIFT_IR;
      default:     n = m ? TS_SEL_DR   : TS_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sfb_tap_fsm.sv
`timescale 1ns/1ps
module sfb_tap_fsm
  import sfb_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= TS_RESET;
    else         state <= tap_next(state, tms);
  end

  // checker: run length of TMS-high clocks, saturating
  localparam int unsigned CW = $clog2(RESET_ONES + 1);
  logic [CW-1:0] ones_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                         ones_cnt <= '0;
    else if (!tms)                       ones_cnt <= '0;
    else if (ones_cnt != CW'(RESET_ONES)) ones_cnt <= ones_cnt + 1'b1;
  end

  // R1
  five_ones_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_cnt == CW'(RESET_ONES)) |-> (state == TS_RESET));

endmodule

// File: rtl/sfb_ir.sv
`timescale 1ns/1ps
module sfb_ir
  import sfb_pkg::*;
#(
  parameter int unsigned          IR_W      = 6,
  parameter logic [IR_W-1:0]      IDCODE_OP = IR_W'('h09)
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_lsb
);

  localparam logic [IR_W-1:0] CAPTURE_PAT = {{(IR_W-1){1'b0}}, 1'b1};

  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh <= '0;
    end else begin
      case (state)
        TS_CAP_IR:   ir_sh <= CAPTURE_PAT;
        TS_SHIFT_IR: ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        default:     ir_sh <= ir_sh;
      endcase
    end
  end

  // the instruction changes on the falling edge so it is settled
  // before the next rising edge acts on it
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                 ir_q <= IDCODE_OP;
    else if (state == TS_RESET)  ir_q <= IDCODE_OP;
    else if (state == TS_UPD_IR) ir_q <= ir_sh;
  end

  assign ir_lsb = ir_sh[0];

  // R3
  ir_update_only_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(ir_q) |-> (state == TS_UPD_IR || state == TS_RESET));

endmodule

// File: rtl/sfb_dr.sv
`timescale 1ns/1ps
module sfb_dr
  import sfb_pkg::*;
#(
  parameter int unsigned     IR_W       = 6,
  parameter int unsigned     ID_W       = 32,
  parameter logic [IR_W-1:0] USER_OP    = IR_W'('h02),
  parameter logic [IR_W-1:0] IDCODE_OP  = IR_W'('h09),
  parameter logic [ID_W-1:0] IDCODE_VAL = ID_W'('h0A571E4D)
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  logic            spi_miso,
  input  tap_state_e      state,
  input  logic [IR_W-1:0] ir_q,
  output logic            dr_out,
  output logic            user_sel
);

  logic            id_sel;
  logic            byp_sel;
  logic            byp_q;
  logic            miso_q;
  logic [ID_W-1:0] id_sh;

  always_comb begin
    user_sel = (ir_q == USER_OP);
    id_sel   = (ir_q == IDCODE_OP);
    byp_sel  = !user_sel && !id_sel;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
      id_sh <= '0;
    end else begin
      case (state)
        TS_CAP_DR: begin
          byp_q <= 1'b0;
          id_sh <= IDCODE_VAL;
        end
        TS_SHIFT_DR: begin
          byp_q <= tdi;
          id_sh <= {tdi, id_sh[ID_W-1:1]};
        end
        default: begin
          byp_q <= byp_q;
          id_sh <= id_sh;
        end
      endcase
    end
  end

  // flash output retimed on the rising edge: one bit of latency
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) miso_q <= 1'b0;
    else         miso_q <= spi_miso;
  end

  always_comb begin
    if (user_sel)    dr_out = miso_q;
    else if (id_sel) dr_out = id_sh[0];
    else             dr_out = byp_q;
  end

  // R4
  bypass_delay_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_SHIFT_DR && byp_sel) |=> (dr_out == $past(tdi)));

  // R7
  miso_to_tdo_chk: assert property (@(posedge tck) disable iff (!trst_n)
    user_sel |=> (!user_sel || dr_out == $past(spi_miso)));

endmodule

// File: rtl/scan_flash_bridge.sv
`timescale 1ns/1ps
module scan_flash_bridge
  import sfb_pkg::*;
#(
  parameter int unsigned     IR_W       = 6,
  parameter int unsigned     ID_W       = 32,
  parameter logic [IR_W-1:0] USER_OP    = IR_W'('h02),
  parameter logic [IR_W-1:0] IDCODE_OP  = IR_W'('h09),
  parameter logic [ID_W-1:0] IDCODE_VAL = ID_W'('h0A571E4D)
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic spi_cs_n,
  output logic spi_sclk,
  output logic spi_mosi,
  input  logic spi_miso
);

  tap_state_e      state;
  logic [IR_W-1:0] ir_q;
  logic            ir_lsb;
  logic            dr_out;
  logic            user_sel;

  sfb_tap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state)
  );

  sfb_ir #(
    .IR_W      (IR_W),
    .IDCODE_OP (IDCODE_OP)
  ) u_ir (
    .tck    (tck),
    .trst_n (trst_n),
    .tdi    (tdi),
    .state  (state),
    .ir_q   (ir_q),
    .ir_lsb (ir_lsb)
  );

  sfb_dr #(
    .IR_W       (IR_W),
    .ID_W       (ID_W),
    .USER_OP    (USER_OP),
    .IDCODE_OP  (IDCODE_OP),
    .IDCODE_VAL (IDCODE_VAL)
  ) u_dr (
    .tck      (tck),
    .trst_n   (trst_n),
    .tdi      (tdi),
    .spi_miso (spi_miso),
    .state    (state),
    .ir_q     (ir_q),
    .dr_out   (dr_out),
    .user_sel (user_sel)
  );

  // the flash is wired straight onto the scan pins
  assign spi_sclk = tck;
  assign spi_mosi = tdi;
  assign spi_cs_n = !(user_sel && state == TS_SHIFT_DR);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo <= 1'b0;
    end else begin
      case (state)
        TS_SHIFT_IR: tdo <= ir_lsb;
        TS_SHIFT_DR: tdo <= dr_out;
        default:     tdo <= 1'b0;
      endcase
    end
  end

  // R5
  cs_fall_entry_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $fell(spi_cs_n) |-> ($past(state) == TS_CAP_DR || $past(state) == TS_EXIT2_DR));

  // R9
  cs_exit_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (!spi_cs_n && tms) |=> spi_cs_n);

  // R10
  tdo_idle_low_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state != TS_SHIFT_IR && state != TS_SHIFT_DR) |-> !tdo);

endmodule

// File: tb/test_scan_flash_bridge.sv
`timescale 1ns/1ps
module test_scan_flash_bridge;

  localparam logic [5:0]  USER_OP = 6'h02;
  localparam logic [5:0]  ID_OP   = 6'h09;
  localparam logic [5:0]  BYP_OP  = 6'h3F;
  localparam logic [5:0]  ODD_OP  = 6'h15;
  localparam logic [31:0] ID_VAL  = 32'h0A571E4D;
  localparam logic [31:0] RESP    = 32'hA53C0F96;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, cs_n, sclk, mosi, miso;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  bit         exp_q[$];
  string      tag_q[$];
  logic [7:0] fexp_q[$];
  string      ftag_q[$];
  bit         mon_req = 0;

  always #2.5 tck = ~tck;

  scan_flash_bridge i_scan_flash_bridge (
    .tck      (tck),
    .trst_n   (trst_n),
    .tms      (tms),
    .tdi      (tdi),
    .tdo      (tdo),
    .spi_cs_n (cs_n),
    .spi_sclk (sclk),
    .spi_mosi (mosi),
    .spi_miso (miso)
  );

  function automatic void check(input logic [63:0] act, input logic [63:0] exp, input string t);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", t, act, exp);
    end
  endfunction

  // ---------------- flash model (SPI mode 0, idle-high output) ----------------
  bit         cs_seen = 1'b1;
  int         nbits = 0;
  int         out_idx = 0;
  logic [7:0] in_byte = 8'h00;

  assign miso = cs_n ? 1'b1 : RESP[31 - (out_idx % 32)];

  always @(negedge sclk) begin
    cs_seen = cs_n;
    if (cs_n) out_idx = 0;
    else      out_idx = nbits;
  end

  // flash-side monitor: pops expected bytes as they complete (R8)
  always @(posedge sclk) begin
    if (cs_seen) begin
      nbits = 0;
    end else begin
      in_byte = {in_byte[6:0], mosi};
      nbits++;
      if (nbits % 8 == 0) begin
        if (fexp_q.size() == 0) begin
          check(in_byte, 64'hx, "R8 unexpected flash byte");
        end else begin
          logic [7:0] e;
          string      t;
          e = fexp_q.pop_front();
          t = ftag_q.pop_front();
          check(in_byte, e, t);
        end
      end
    end
  end

  // TDO monitor: compares against bits the driver queued
  always @(negedge tck) begin
    #2;
    if (mon_req) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(tdo, e, t);
    end
  end

  // ---------------- driver ----------------
  task automatic tick(input bit m, input bit d, input bit chk, input bit e, input string t);
    @(negedge tck);
    #1;
    tms = m;
    tdi = d;
    if (chk) begin
      exp_q.push_back(e);
      tag_q.push_back(t);
      mon_req = 1'b1;
    end
    @(posedge tck);
    #0.5;
    mon_req = 1'b0;
  endtask

  task automatic to_idle();
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 1'b0, 1'b0, "");
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
  endtask

  task automatic load_ir(input logic [5:0] op);
    tick(1'b1, 1'b0, 1'b0, 1'b0, "");
    tick(1'b1, 1'b0, 1'b0, 1'b0, "");
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
    for (int i = 0; i < 6; i++)
      tick(i == 5, op[i], 1'b1, i == 0, "R3 capture-IR pattern");
    tick(1'b1, 1'b0, 1'b0, 1'b0, "");
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
  endtask

  task automatic enter_shift_dr();
    tick(1'b1, 1'b0, 1'b0, 1'b0, "");
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, input logic [63:0] dexp,
                         input bit exp_cs, input string t);
    enter_shift_dr();
    check(cs_n, exp_cs, "R5 chip select during Shift-DR");
    for (int i = 0; i < n; i++)
      tick(i == n - 1, din[i], 1'b1, dexp[i], t);
    check(cs_n, 1'b1, "R9 chip select after Exit1-DR");
    tick(1'b1, 1'b0, 1'b0, 1'b0, "");
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
  endtask

  // ---------------- scenarios ----------------
  initial begin
    logic [63:0] din, dexp;
    logic [31:0] tx;

    #12;
    check(cs_n, 1'b1, "R11 cs_n during reset");
    check(tdo, 1'b0, "R11 tdo during reset");
    @(negedge tck);
    #1;
    trst_n = 1'b1;
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
    check(tdo, 1'b0, "R10 tdo low in Run-Test-Idle");

    // R2: identification register after reset
    scan_dr(32, 64'h0, {32'h0, ID_VAL}, 1'b1, "R2 IDCODE bit");

    // R4: explicit bypass
    load_ir(BYP_OP);
    din = 64'hB4;
    dexp = {din[62:0], 1'b0};
    scan_dr(8, din, dexp, 1'b1, "R4 bypass delay");

    // R4: unassigned opcode behaves as bypass
    load_ir(ODD_OP);
    din = 64'h3C96;
    dexp = {din[62:0], 1'b0};
    scan_dr(16, din, dexp, 1'b1, "R4 unknown opcode bypass");

    // R5/R7/R8: flash read with three bytes sent MSB first
    load_ir(USER_OP);
    check(cs_n, 1'b1, "R5 cs_n high in Run-Test-Idle with flash opcode");
    tx = 32'h0B_81_00_00;
    fexp_q.push_back(tx[31:24]); ftag_q.push_back("R8 flash byte 0");
    fexp_q.push_back(tx[23:16]); ftag_q.push_back("R8 flash byte 1");
    fexp_q.push_back(tx[15:8]);  ftag_q.push_back("R8 flash byte 2");
    din = '0;
    dexp = '0;
    for (int i = 0; i < 24; i++) din[i] = tx[31 - i];
    dexp[0] = 1'b1;
    for (int i = 1; i < 24; i++) dexp[i] = RESP[31 - (i - 1)];
    scan_dr(24, din, dexp, 1'b0, "R7 retimed flash read");

    // R9: pause splits the shift into two transactions
    fexp_q.push_back(8'h9F); ftag_q.push_back("R9 byte before pause");
    fexp_q.push_back(8'h5A); ftag_q.push_back("R9 byte after pause restarts");
    enter_shift_dr();
    check(cs_n, 1'b0, "R5 cs_n low in Shift-DR");
    check(sclk, 1'b1, "R6 sclk follows tck high");
    check(mosi, tdi, "R6 mosi follows tdi");
    for (int i = 0; i < 8; i++)
      tick(i == 7, 8'h9F >> (7 - i), 1'b1, (i == 0) ? 1'b1 : RESP[31 - (i - 1)], "R7 first segment");
    check(cs_n, 1'b1, "R9 cs_n high in Exit1-DR");
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
    check(cs_n, 1'b1, "R9 cs_n high in Pause-DR");
    tick(1'b1, 1'b0, 1'b0, 1'b0, "");
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
    check(cs_n, 1'b0, "R9 cs_n low again after Exit2-DR");
    for (int i = 0; i < 8; i++)
      tick(i == 7, 8'h5A >> (7 - i), 1'b1, (i == 0) ? 1'b1 : RESP[31 - (i - 1)], "R9 second segment data restart");
    tick(1'b1, 1'b0, 1'b0, 1'b0, "");
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
    @(negedge tck);
    #1;
    check(sclk, 1'b0, "R6 sclk follows tck low");

    // R1: five TMS-high clocks from Shift-DR reset the TAP
    enter_shift_dr();
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 1'b0, 1'b0, "");
    check(cs_n, 1'b1, "R1 cs_n high after TMS escape");
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
    scan_dr(32, 64'h0, {32'h0, ID_VAL}, 1'b1, "R1 IDCODE reselected");

    // R11: asynchronous reset in the middle of a flash shift
    load_ir(USER_OP);
    enter_shift_dr();
    tick(1'b0, 1'b1, 1'b0, 1'b0, "");
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
    trst_n = 1'b0;
    #0.5;
    check(cs_n, 1'b1, "R11 cs_n released by async reset");
    check(tdo, 1'b0, "R11 tdo cleared by async reset");
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
    @(negedge tck);
    #1;
    trst_n = 1'b1;
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
    scan_dr(32, 64'h0, {32'h0, ID_VAL}, 1'b1, "R11 IDCODE after async reset");

    repeat (3) @(negedge tck);
    check(exp_q.size(), 0, "R7 all TDO bits compared");
    check(fexp_q.size(), 0, "R8 all flash bytes received");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule